// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block turns a free-running parent clock into a clock-enable strobe for a CPU clock domain. It works in windows of 32 parent cycles. In each window it passes a programmable number of raw pulses, `mult`, spread evenly across the window by an accumulator. A fixed post-divider then keeps only one of every `POST_DIV` raw pulses. Over any span of `32 * POST_DIV` parent cycles the strobe fires exactly `mult` times. The effective rate is therefore parent × mult / 32 / POST_DIV.

Software uses two registers. The control register holds a 5-bit rate field encoded as `32 - mult`, so a field of 0 means full rate. The commit register has a kick bit at bit 31. Writing the field alone only stages a value. Setting kick commits the staged value. The value is applied at the next window boundary, and the block clears kick by itself a fixed number of cycles later. While kick is pending, the block reports busy and ignores writes to the field.

Top module: `fracrate_ctl`

## Requirements
- R1: After reset the staged field and the active field are 0, kick and `busy_o` are low, and the strobe runs at full rate: 32 strobes in every 32*POST_DIV cycles.
- R2: With an active field value F, `en_o` pulses exactly 32-F times in any 32*POST_DIV consecutive cycles. F = 0 means mult = 32, and F = 31 means mult = 1.
- R3: The control register is at address `CTRL_ADDR` (default 0x0). The rate field occupies bits [FIELD_LSB+4:FIELD_LSB] (FIELD_LSB default 8). A read returns the staged field there, and every other bit reads 0.
- R4: A field write that is not followed by a kick changes the read-back value but does not change the strobe rate.
- R5: Writing 1 to bit 31 of the commit register at `KICK_ADDR` (default 0x4) sets kick. From the next cycle, bit 31 of that register reads 1 and `busy_o` is high.
- R6: A committed field becomes active only in the cycle after the last cycle of a 32-cycle window. Kick and `busy_o` drop KICK_LAT cycles after the new value becomes active (KICK_LAT default 4). At most 32+KICK_LAT cycles pass between the kick write and the clear.
- R7: A write to the control register while kick is set is rejected. The staged field keeps its value, and the rate applied by the pending kick is unaffected.
- R8: Strobes are spread evenly. When mult divides 32, consecutive strobes are exactly 32*POST_DIV/mult cycles apart. Two strobes never occur in adjacent cycles.
- R9: A write to the commit register with bit 31 clear has no effect. A kick write while kick is already set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| busy_o | output | 1 | Kick pending, mirrors commit bit 31 |
| en_o | output | 1 | Clock-enable strobe, registered |

## Verification
The rate is measured at full rate (F=0), at half and quarter rate (F=16 and F=24), at the single-pulse extreme (F=31), and at a non-power-of-two multiplier (F=12, mult=20). Together these separate a correct accumulator from one that counts the field directly or miscounts the overflow. Strobe spacing is measured at mult 32, 16 and 8; this tells even spreading apart from bunching at the start of a window. The handshake is exercised by staging without a kick, by a field write while kick is pending, by a zero write and a repeated write to the commit register, and by timing how long kick stays set.

// File: rtl/fracrate_pkg.sv
package fracrate_pkg;
    localparam int FLD_W    = 5;
    localparam int WIN_LEN  = 32;
    localparam int KICK_BIT = 31;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARMED,
        KS_SETTLE
    } kick_st_e;

    // Stored field encodes 32 - mult.
    function automatic logic [FLD_W:0] mult_of(input logic [FLD_W-1:0] fld);
        return 6'(WIN_LEN) - {1'b0, fld};
    endfunction
endpackage

// File: rtl/fracrate_regs.sv
module fracrate_regs
    import fracrate_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int KICK_LAT  = 4,
    parameter int ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              win_last,
    output logic [FLD_W-1:0]  pend_fld,
    output logic [FLD_W-1:0]  act_fld,
    output logic              busy
);
    localparam int CNT_W = $clog2(KICK_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KICK_LAT - 1);

    kick_st_e         st;
    logic [CNT_W-1:0] settle_cnt;
    logic             ctrl_wr, kick_wr;

    assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
    assign kick_wr = bus_we && (bus_addr == KICK_ADDR);
    assign busy    = (st != KS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= KS_IDLE;
            pend_fld   <= '0;
            act_fld    <= '0;
            settle_cnt <= '0;
        end else begin
            if (ctrl_wr && st == KS_IDLE)
                pend_fld <= bus_wdata[FIELD_LSB +: FLD_W];
            unique case (st)
                KS_IDLE: begin
                    if (kick_wr && bus_wdata[KICK_BIT])
                        st <= KS_ARMED;
                end
                KS_ARMED: begin
                    if (win_last) begin
                        act_fld    <= pend_fld;
                        settle_cnt <= '0;
                        st         <= KS_SETTLE;
                    end
                end
                KS_SETTLE: begin
                    if (settle_cnt == CNT_LAST)
                        st <= KS_IDLE;
                    else
                        settle_cnt <= settle_cnt + 1'b1;
                end
                default: st <= KS_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR)
            bus_rdata[FIELD_LSB +: FLD_W] = pend_fld;
        else if (bus_addr == KICK_ADDR)
            bus_rdata[KICK_BIT] = busy;
    end
endmodule

// File: rtl/fracrate_accum.sv
module fracrate_accum
    import fracrate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [FLD_W-1:0] act_fld,
    output logic             raw_fire,
    output logic             win_last
);
    localparam int WCNT_W = $clog2(WIN_LEN);

    logic [WCNT_W-1:0] wcnt;
    logic [FLD_W-1:0]  acc;
    logic [FLD_W:0]    sum;

    assign sum      = {1'b0, acc} + mult_of(act_fld);
    assign raw_fire = sum[FLD_W];
    assign win_last = (wcnt == WCNT_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            acc  <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
            acc  <= sum[FLD_W-1:0];
        end
    end
endmodule

// File: rtl/fracrate_postdiv.sv
module fracrate_postdiv #(
    parameter int POST_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_fire,
    output logic en_o
);
    localparam int PC_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(POST_DIV - 1);

    generate
        if (POST_DIV > 1) begin : g_div
            logic [PC_W-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt <= '0;
                    en_o <= 1'b0;
                end else begin
                    en_o <= raw_fire && (pcnt == PC_LAST);
                    if (raw_fire)
                        pcnt <= (pcnt == PC_LAST) ? '0 : pcnt + 1'b1;
                end
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) en_o <= 1'b0;
                else     en_o <= raw_fire;
            end
        end
    endgenerate
endmodule

// File: rtl/fracrate_ctl.sv
module fracrate_ctl
    import fracrate_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int KICK_LAT  = 4,
    parameter int POST_DIV  = 2,
    parameter int ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              busy_o,
    output logic              en_o
);
    logic [FLD_W-1:0] pend_fld, act_fld;
    logic             win_last, raw_fire;

    fracrate_regs #(
        .FIELD_LSB(FIELD_LSB), .KICK_LAT(KICK_LAT), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .KICK_ADDR(KICK_ADDR)
    ) regs_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .win_last(win_last),
        .pend_fld(pend_fld), .act_fld(act_fld), .busy(busy_o)
    );

    fracrate_accum accum_i (
        .clk(clk), .rst(rst), .act_fld(act_fld),
        .raw_fire(raw_fire), .win_last(win_last)
    );

    fracrate_postdiv #(.POST_DIV(POST_DIV)) pdiv_i (
        .clk(clk), .rst(rst), .raw_fire(raw_fire), .en_o(en_o)
    );
endmodule

// File: rtl/fracrate_chk.sv
module fracrate_chk
    import fracrate_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int POST_DIV  = 2,
    parameter int ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 'h4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              busy_o,
    input logic              en_o,
    input logic [FLD_W-1:0]  pend_fld,
    input logic [FLD_W-1:0]  act_fld,
    input logic              win_last
);
    localparam logic [31:0] FMASK = 32'h1F << FIELD_LSB;

    // R3
    ctrl_read_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |-> ((bus_rdata & ~FMASK) == 32'h0));

    // R5
    kick_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == KICK_ADDR && bus_wdata[KICK_BIT] && !busy_o) |=> busy_o);

    // R7
    locked_field_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR && busy_o) |=> $stable(pend_fld));

    // R6
    act_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_fld) |-> $past(win_last));

    // R6
    act_change_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_fld) |-> busy_o);

    // R8
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (en_o && POST_DIV > 1) |=> !en_o);
endmodule

bind fracrate_ctl fracrate_chk #(
    .FIELD_LSB(FIELD_LSB), .POST_DIV(POST_DIV), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .KICK_ADDR(KICK_ADDR)
) chk_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_o(busy_o),
    .en_o(en_o), .pend_fld(pend_fld), .act_fld(act_fld), .win_last(win_last)
);

// File: tb/fracrate_ctl_tb_top.sv
module fracrate_ctl_tb_top;
    localparam int FIELD_LSB = 8;
    localparam int KICK_LAT  = 4;
    localparam int POST_DIV  = 2;
    localparam int ADDR_W    = 4;
    localparam int SPAN      = 32 * POST_DIV;
    localparam logic [ADDR_W-1:0] CTRL_A = 'h0;
    localparam logic [ADDR_W-1:0] KICK_A = 'h4;
    localparam int WD_LIMIT  = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              busy_o, en_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit wd_hit   = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    event  meas_req, meas_done;

    always #5 clk = ~clk;

    fracrate_ctl #(
        .FIELD_LSB(FIELD_LSB), .KICK_LAT(KICK_LAT), .POST_DIV(POST_DIV),
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_A), .KICK_ADDR(KICK_A)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_o(busy_o), .en_o(en_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver side of the scoreboard: queue the expected strobe count.
    task automatic expect_rate(input int fld, input string tag);
        exp_q.push_back(32 - fld);
        tag_q.push_back(tag);
        ->meas_req;
        @(meas_done);
    endtask

    // Monitor: counts strobes over one span and compares with the queue head.
    initial begin
        forever begin
            int cnt;
            int e;
            string t;
            @(meas_req);
            cnt = 0;
            for (int i = 0; i < SPAN; i++) begin
                @(negedge clk);
                if (en_o) cnt++;
            end
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cnt, e, t);
            ->meas_done;
        end
    end

    task automatic expect_gap(input int gap, input string tag);
        int last;
        int bad;
        last = -1; bad = 0;
        for (int i = 0; i < 2 * SPAN; i++) begin
            @(negedge clk);
            if (en_o) begin
                if (last >= 0 && (i - last) != gap) bad = i - last;
                last = i;
            end
        end
        check(bad, 0, tag);
    endtask

    task automatic kick_and_wait(input string tag);
        logic [31:0] d;
        int n;
        bus_write(KICK_A, 32'h8000_0000);
        n = 1;
        bus_read(KICK_A, d);
        check(int'(d[31]), 1, {tag, " R5 kick reads set"});
        check(int'(busy_o), 1, {tag, " R5 busy high"});
        while (d[31] && n < 32 + KICK_LAT + 8) begin
            bus_read(KICK_A, d);
            n++;
        end
        check(int'(d[31]), 0, {tag, " R6 kick self-clears"});
        check(int'(n >= KICK_LAT && n <= 32 + KICK_LAT + 1), 1, {tag, " R6 clear latency in range"});
    endtask

    task automatic run_all();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(CTRL_A, d);
        check(int'(d), 0, "R1 ctrl reads zero");
        bus_read(KICK_A, d);
        check(int'(d), 0, "R1 kick reads zero");
        check(int'(busy_o), 0, "R1 busy low");
        expect_rate(0, "R1 full rate after reset");
        expect_gap(POST_DIV, "R8 gap at mult 32");

        // R3 staging and readback, R4 no effect without kick
        bus_write(CTRL_A, 32'hFFFF_FFFF);
        bus_read(CTRL_A, d);
        check(int'(d), int'(32'h1F << FIELD_LSB), "R3 only field bits read back");
        bus_write(CTRL_A, 32'(16) << FIELD_LSB);
        bus_read(CTRL_A, d);
        check(int'(d), int'(32'(16) << FIELD_LSB), "R3 field readback");
        expect_rate(0, "R4 staged field does not change rate");

        // R9 zero write to commit register
        bus_write(KICK_A, 32'h7FFF_FFFF);
        bus_read(KICK_A, d);
        check(int'(d), 0, "R9 kick with bit31 clear ignored");
        check(int'(busy_o), 0, "R9 busy stays low");

        // R2 half rate
        kick_and_wait("F16");
        expect_rate(16, "R2 mult 16");
        expect_gap(SPAN / 16, "R8 gap at mult 16");

        // R7 write during pending kick, R9 repeated kick
        bus_write(CTRL_A, 32'(24) << FIELD_LSB);
        bus_write(KICK_A, 32'h8000_0000);
        bus_write(CTRL_A, 32'(5) << FIELD_LSB);
        bus_write(KICK_A, 32'h8000_0000);
        bus_read(CTRL_A, d);
        check(int'(d), int'(32'(24) << FIELD_LSB), "R7 locked field readback");
        repeat (32 + KICK_LAT + 2) @(negedge clk);
        check(int'(busy_o), 0, "R9 repeated kick does not extend busy");
        expect_rate(24, "R7 rate follows committed field");
        expect_gap(SPAN / 8, "R8 gap at mult 8");

        // R2 extreme and non-power-of-two
        bus_write(CTRL_A, 32'(31) << FIELD_LSB);
        kick_and_wait("F31");
        expect_rate(31, "R2 mult 1");
        expect_rate(31, "R2 mult 1 second span");
        bus_write(CTRL_A, 32'(12) << FIELD_LSB);
        kick_and_wait("F12");
        expect_rate(12, "R2 mult 20");
        bus_write(CTRL_A, 32'(0) << FIELD_LSB);
        kick_and_wait("F0");
        expect_rate(0, "R2 back to full rate");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD_LIMIT) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_checks++;
            n_fails++;
            $display("FAIL R6 watchdog: actual=hung expected=completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule